// File: doc/BRIEF.md
# Reset Origin Sequencer

This block sits on the processor side of a shared, active-low, open-drain reset line. Whenever the processor's own fault logic requests a reset, the block pulls the line low for a set number of clock cycles. It then lets go, waits a set number of cycles and reads the line. If some other device on the line is still holding it low, the reset is classed as external. If the line has already come back high, the reset is classed as self-caused.

The result is given on a vector-select flag. A high flag means external: take the normal vector and start from scratch, discarding stored state. A low flag means internal: take the alternate vector and keep stored state. A one-cycle start pulse is issued once the line is seen high on two consecutive cycles.

A low on the line that the block did not cause, seen while idle, skips the drive phase and goes straight to waiting for high with the external class. A line that rises too slowly to be high at the sample point makes the reset look external. This is an intended outcome of the scheme, not a fault of the block.

Top module: `rst_origin_seq`

## Requirements
- R1: After `rst_n` is released, `pin_drive` is 0, `start` is 0 and `src_ext` is 0 until a stimulus arrives.
- R2: A `fault_req` sampled high at clock edge k asserts `pin_drive` for exactly DRIVE_CYC cycles, starting right after edge k (edges k to k+DRIVE_CYC-1).
- R3: After the drive phase, the line is left released for WAIT_CYC cycles. It is then sampled once, at edge k+DRIVE_CYC+WAIT_CYC+1, which is edge k+7 with the defaults.
- R4: If `pin_in` is 0 at the sample edge, `src_ext` becomes 1 (external). This includes a line that rises too slowly.
- R5: If `pin_in` is 1 at the sample edge, `src_ext` becomes 0 (self-caused).
- R6: `start` is raised only after `pin_in` has been 1 at two consecutive edges while waiting for high. A single high edge between lows does not raise it.
- R7: `start` is high for exactly one cycle. `src_ext` keeps its value through that cycle and afterwards, until the next sequence classifies again.
- R8: While idle, `pin_in` at 0 with no request moves the block to wait-for-high with `src_ext` at 1 and no drive.
- R9: A `fault_req` at any point of a running sequence restarts the drive phase, and the timing counts from the new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock; all phase lengths are counted in its cycles |
| rst_n | input | 1 | Active-low reset of the sequencer logic |
| fault_req | input | 1 | Internal reset request from the processor's fault logic |
| pin_in | input | 1 | Synchronised level of the shared reset line |
| pin_drive | output | 1 | When 1, the line is pulled low |
| src_ext | output | 1 | Vector select: 1 external/normal, 0 self-caused/alternate |
| start | output | 1 | One-cycle pulse to begin execution from the selected vector |

## Verification
The bench uses the default DRIVE_CYC of 4 and WAIT_CYC of 2, so the line is sampled at the seventh edge after the request. It walks an external hold time across that edge: lengths of 7 and 8 land on either side of the sample, so one sequence is classed internal and the next external, and the start delay is checked for each. Short phase counts also keep the restart, the one-edge high glitch and the idle-low entry within a few cycles, so each can be timed exactly.

// File: rtl/rst_origin_seq.sv
module rst_origin_seq #(
  parameter int DRIVE_CYC = 4,
  parameter int WAIT_CYC  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_req,
  input  logic pin_in,
  output logic pin_drive,
  output logic src_ext,
  output logic start
);
  localparam int CMAX = (DRIVE_CYC > WAIT_CYC) ? DRIVE_CYC : WAIT_CYC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] DLAST = CW'(DRIVE_CYC - 1);
  localparam logic [CW-1:0] WLAST = CW'(WAIT_CYC - 1);

  typedef enum logic [2:0] {S_IDLE, S_DRIVE, S_WAIT, S_SAMPLE, S_HOLD} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          seen_hi;

  assign pin_drive = (st == S_DRIVE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      seen_hi <= 1'b0;
      src_ext <= 1'b0;
      start   <= 1'b0;
    end else begin
      start <= 1'b0;
      if (fault_req) begin
        st      <= S_DRIVE;
        cnt     <= '0;
        seen_hi <= 1'b0;
      end else begin
        case (st)
          S_IDLE: if (!pin_in) begin
            st      <= S_HOLD;
            src_ext <= 1'b1;
            seen_hi <= 1'b0;
          end
          S_DRIVE: if (cnt == DLAST) begin
            st  <= S_WAIT;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
          S_WAIT: if (cnt == WLAST) begin
            st  <= S_SAMPLE;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
          S_SAMPLE: begin
            src_ext <= ~pin_in;
            seen_hi <= pin_in;
            st      <= S_HOLD;
          end
          S_HOLD: if (pin_in && seen_hi) begin
            start   <= 1'b1;
            seen_hi <= 1'b0;
            st      <= S_IDLE;
          end else seen_hi <= pin_in;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);  // R7
  AST_START_AFTER_TWO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start) |-> ($past(pin_in) && $past(pin_in, 2)));  // R6
  AST_REQ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    fault_req |=> pin_drive);  // R9
  AST_NO_DRIVE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !pin_drive);  // R2
  AST_IDLE_LOW_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !pin_in && !fault_req) |=> (src_ext && !pin_drive));  // R8
  AST_CLASS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD && $past(st == S_HOLD)) |-> $stable(src_ext));  // R7
endmodule

// File: tb/sim_rst_origin_seq.sv
module sim_rst_origin_seq;
  logic clk = 1'b0, rst_n = 1'b0, fault_req = 1'b0, ext_low = 1'b0;
  logic pin_drive, src_ext, start, pin_in;
  int checks = 0, failures = 0, cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  assign pin_in = !(pin_drive || ext_low);

  rst_origin_seq #(.DRIVE_CYC(4), .WAIT_CYC(2)) u0 (
    .clk(clk), .rst_n(rst_n), .fault_req(fault_req), .pin_in(pin_in),
    .pin_drive(pin_drive), .src_ext(src_ext), .start(start));

  // hold length, expected src_ext, expected start edge offset
  localparam int VEC[5][3] = '{'{0, 0, 8}, '{6, 0, 8}, '{7, 0, 8}, '{8, 1, 9}, '{12, 1, 13}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      failures++;
      done = 1'b1;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 5000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Runs one request; ext_low held for edges 0..hold-1; restart re-requests at edge rs (rs<0: none)
  task automatic run(input int hold, input int rs, output int lat, output int drv, output int ext);
    lat = -1; drv = 0; ext = -1;
    @(negedge clk);
    fault_req = 1'b1;
    ext_low = (hold > 0);
    for (int e = 0; e < 40 && lat < 0; e++) begin
      @(posedge clk);
      @(negedge clk);
      if (pin_drive) drv++;
      if (start) begin lat = e; ext = src_ext; end
      fault_req = (rs == e + 1);
      ext_low = (e + 1 < hold);
    end
  endtask

  initial begin
    int lat, drv, ext;
    repeat (3) @(negedge clk);
    chk(pin_drive == 0 && start == 0 && src_ext == 0, "R1", {pin_drive, start, src_ext}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(pin_drive == 0 && start == 0 && src_ext == 0, "R1 idle", {pin_drive, start, src_ext}, 0);

    for (int i = 0; i < 5; i++) begin
      run(VEC[i][0], -1, lat, drv, ext);
      chk(drv == 4, "R2 drive cycles", drv, 4);
      chk(lat == VEC[i][2], "R3 start edge", lat, VEC[i][2]);
      chk(ext == VEC[i][1], VEC[i][1] ? "R4 external" : "R5 self-caused", ext, VEC[i][1]);
      @(negedge clk);
      chk(start == 0, "R7 pulse width", start, 0);
      chk(src_ext == VEC[i][1], "R7 class held", src_ext, VEC[i][1]);
    end

    // R9: second request sampled at edge 3 restarts the drive phase
    run(0, 3, lat, drv, ext);
    chk(drv == 7, "R9 drive cycles", drv, 7);
    chk(lat == 11, "R9 start edge", lat, 11);
    chk(ext == 0, "R9 class", ext, 0);

    // R8 and R6: undriven low in idle, then a single-edge high glitch
    @(negedge clk);
    chk(src_ext == 0, "R8 pre-class", src_ext, 0);
    ext_low = 1'b1;
    @(negedge clk);
    chk(src_ext == 1 && pin_drive == 0, "R8 external no drive", {src_ext, pin_drive}, 2);
    ext_low = 1'b0;
    @(negedge clk);
    chk(start == 0, "R6 one high edge", start, 0);
    ext_low = 1'b1;
    @(negedge clk);
    chk(start == 0, "R6 glitch low", start, 0);
    ext_low = 1'b0;
    @(negedge clk);
    chk(start == 0, "R6 first high", start, 0);
    @(negedge clk);
    chk(start == 1, "R6 second high start", start, 1);
    chk(src_ext == 1, "R8 class at start", src_ext, 1);
    @(negedge clk);
    chk(start == 0, "R7 pulse end", start, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule